// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Read Controller

This block is the host side of a four-wire synchronous link to an eight-channel delta-sigma converter. A start request lowers chip select. The controller then polls the converter's data line, which serves as a ready flag. When that flag reads low, the controller generates one 32-pulse serial frame. In the same frame it sends a 14-bit setup word, most significant bit first, and collects the 32-bit conversion word from the converter.

The setup word sets the input channel, single-ended or differential mode, polarity, reference choice, oversampling ratio and the double-speed option. It is captured, together with the clock divider value, when the request is accepted. At the end of the frame, the block turns the offset-binary code with its separate sign bit into a 24-bit two's-complement value. Codes that show a clamped input above or below full scale saturate the value and raise a flag.

If the ready flag never goes low, a wait counter ends the attempt and reports a timeout.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is asserted, and until the first accepted request, chip select is high, the serial clock is low, and busy, result_valid and timeout are low.
- R2: A start request seen in idle drives chip select low from the next cycle, and busy tracks chip select low. A request seen while a transfer is running has no effect on that transfer.
- R3: While waiting, the data line is sampled on every system clock. The serial clock stays low until a low level has been sampled, and its first rising edge comes clk_div+1 cycles after that sample.
- R4: A frame has exactly 32 serial clock pulses. High and low phases last clk_div+1 system clocks each, using the divider value captured at acceptance.
- R5: On the first 14 pulses, mosi carries the word 1,0,1,single,odd,glbl,addr[1],addr[0],osr[3],osr[2],osr[1],osr[0],twox,0, first element first. After that it carries zeros. All fields are captured at acceptance.
- R6: With cfg_en low at acceptance, the word sent is 1,0,0 followed by eleven zeros.
- R7: mosi changes only on a falling serial clock edge, or on entry into the frame. It holds while the serial clock is high.
- R8: Data is captured on rising edges. In the system clock right after the 32nd falling edge, chip select rises and result_valid is high for exactly that one cycle.
- R9: Label frame bits 31 (first received) down to 0. For an in-range frame (bit29 differs from bit28), the result is {~bit29, bits 27..5} in two's complement, and both range flags are low.
- R10: A frame with bit29=1 and bit28=1 gives result 0x7FFFFF and sets over_range.
- R11: A frame with bit29=0 and bit28=0 gives result 0x800000 and sets under_range.
- R12: If no low level is sampled within TMO_CYCLES wait clocks, chip select rises on the TMO_CYCLES-th wait edge and timeout is high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a conversion read |
| cfg_en_i | input | 1 | Send new settings (low keeps the previous ones) |
| cfg_single_i | input | 1 | Single-ended input select |
| cfg_odd_i | input | 1 | Polarity / odd channel select |
| cfg_glbl_i | input | 1 | Reference choice bit |
| cfg_addr_i | input | 2 | Channel address |
| cfg_osr_i | input | 4 | Oversampling ratio code |
| cfg_twox_i | input | 1 | Double-speed option |
| clk_div_i | input | DIV_W | Serial clock half-period minus one, in system clocks |
| cs_n_o | output | 1 | Chip select, active low |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Setup word to the converter |
| miso_i | input | 1 | Converter data line and ready flag |
| busy_o | output | 1 | Transfer or wait in progress |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| result_o | output | 24 | Signed result, held until the next one |
| over_range_o | output | 1 | Last result clamped above full scale |
| under_range_o | output | 1 | Last result clamped below full scale |
| timeout_o | output | 1 | One-cycle strobe when the ready wait expired |

## Verification
The assertions assume that the converter changes its data line only after a falling serial clock edge or while chip select is high. They also assume that start_i and the setup inputs are driven synchronously to clk. The bench's converter model updates its line from the falling edges of the controller's own clock. All bench stimulus changes on the falling system clock edge, well away from sampling. Ready delays stay below the timeout limit, except in the one case that is meant to expire.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int FRAME_BITS = 32;
  localparam int CFG_BITS   = 14;
  localparam int SIGN_POS   = 29;
  localparam int MSB_POS    = 28;
  localparam int RES_BITS   = 24;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } host_state_t;

  typedef struct packed {
    logic       en;
    logic       sgl;
    logic       odd;
    logic       glbl;
    logic [1:0] addr;
    logic [3:0] osr;
    logic       twox;
  } host_cfg_t;
endpackage

// File: rtl/adc_host_rstsync.sv
module adc_host_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  // asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/adc_host_clkdiv.sv
module adc_host_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == div_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/adc_host_cfgword.sv
module adc_host_cfgword
  import adc_host_pkg::*;
(
  input  host_cfg_t           cfg_i,
  output logic [CFG_BITS-1:0] word_o
);
  // leading 1,0 preamble, then enable; disabled words keep old settings
  always_comb begin
    if (cfg_i.en)
      word_o = {2'b10, 1'b1, cfg_i.sgl, cfg_i.odd, cfg_i.glbl,
                cfg_i.addr, cfg_i.osr, cfg_i.twox, 1'b0};
    else
      word_o = {2'b10, 1'b0, {(CFG_BITS-3){1'b0}}};
  end
endmodule

// File: rtl/adc_host_decode.sv
module adc_host_decode
  import adc_host_pkg::*;
(
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic [RES_BITS-1:0]   value_o,
  output logic                  over_o,
  output logic                  under_o
);
  logic sign_b, top_b;

  assign sign_b  = frame_i[SIGN_POS];
  assign top_b   = frame_i[MSB_POS];
  assign over_o  = sign_b && top_b;
  assign under_o = !sign_b && !top_b;

  // sign bit is the inverted top bit of an offset-binary code
  always_comb begin
    if (over_o)       value_o = {1'b0, {(RES_BITS-1){1'b1}}};
    else if (under_o) value_o = {1'b1, {(RES_BITS-1){1'b0}}};
    else              value_o = {~sign_b, frame_i[MSB_POS-1 -: RES_BITS-1]};
  end
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host
  import adc_host_pkg::*;
#(
  parameter int DIV_W      = 8,
  parameter int TMO_CYCLES = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cfg_en_i,
  input  logic             cfg_single_i,
  input  logic             cfg_odd_i,
  input  logic             cfg_glbl_i,
  input  logic [1:0]       cfg_addr_i,
  input  logic [3:0]       cfg_osr_i,
  input  logic             cfg_twox_i,
  input  logic [DIV_W-1:0] clk_div_i,
  output logic             cs_n_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             result_valid_o,
  output logic [23:0]      result_o,
  output logic             over_range_o,
  output logic             under_range_o,
  output logic             timeout_o
);
  localparam int TMO_W = $clog2(TMO_CYCLES + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

  logic                  rst_ns;
  logic                  tick;
  host_cfg_t             cfg_live;
  logic [CFG_BITS-1:0]   word_live;
  logic [RES_BITS-1:0]   dec_val;
  logic                  dec_over, dec_under;

  host_state_t           state_q, state_d;
  logic                  cs_n_q, cs_n_d;
  logic                  sck_q, sck_d;
  logic                  mosi_q, mosi_d;
  logic [CFG_BITS-1:0]   cfg_sh_q, cfg_sh_d;
  logic [DIV_W-1:0]      div_q, div_d;
  logic [TMO_W-1:0]      wait_q, wait_d;
  logic [BIT_W-1:0]      bit_q, bit_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic                  valid_q, valid_d;
  logic                  tmo_q, tmo_d;
  logic [RES_BITS-1:0]   res_q, res_d;
  logic                  over_q, over_d;
  logic                  under_q, under_d;

  adc_host_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_ns)
  );

  assign cfg_live.en   = cfg_en_i;
  assign cfg_live.sgl  = cfg_single_i;
  assign cfg_live.odd  = cfg_odd_i;
  assign cfg_live.glbl = cfg_glbl_i;
  assign cfg_live.addr = cfg_addr_i;
  assign cfg_live.osr  = cfg_osr_i;
  assign cfg_live.twox = cfg_twox_i;

  adc_host_cfgword u_word (
    .cfg_i  (cfg_live),
    .word_o (word_live)
  );

  adc_host_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_ns),
    .run_i  (state_q == ST_SHIFT),
    .div_i  (div_q),
    .tick_o (tick)
  );

  adc_host_decode u_dec (
    .frame_i (sh_q),
    .value_o (dec_val),
    .over_o  (dec_over),
    .under_o (dec_under)
  );

  always_comb begin
    state_d  = state_q;
    cs_n_d   = cs_n_q;
    sck_d    = sck_q;
    mosi_d   = mosi_q;
    cfg_sh_d = cfg_sh_q;
    div_d    = div_q;
    wait_d   = wait_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    valid_d  = 1'b0;
    tmo_d    = 1'b0;
    res_d    = res_q;
    over_d   = over_q;
    under_d  = under_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_WAIT;
          cs_n_d   = 1'b0;
          cfg_sh_d = word_live;
          div_d    = clk_div_i;
          wait_d   = '0;
        end
      end
      ST_WAIT: begin
        if (!miso_i) begin
          state_d  = ST_SHIFT;
          sck_d    = 1'b0;
          bit_d    = '0;
          mosi_d   = cfg_sh_q[CFG_BITS-1];
          cfg_sh_d = {cfg_sh_q[CFG_BITS-2:0], 1'b0};
        end else if (wait_q == TMO_LAST) begin
          state_d = ST_IDLE;
          cs_n_d  = 1'b1;
          tmo_d   = 1'b1;
        end else begin
          wait_d = wait_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d = 1'b1;
            sh_d  = {sh_q[FRAME_BITS-2:0], miso_i};
          end else begin
            sck_d = 1'b0;
            if (bit_q == BIT_LAST) begin
              state_d = ST_IDLE;
              cs_n_d  = 1'b1;
              mosi_d  = 1'b0;
              valid_d = 1'b1;
              res_d   = dec_val;
              over_d  = dec_over;
              under_d = dec_under;
            end else begin
              bit_d    = bit_q + 1'b1;
              mosi_d   = cfg_sh_q[CFG_BITS-1];
              cfg_sh_d = {cfg_sh_q[CFG_BITS-2:0], 1'b0};
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q  <= ST_IDLE;
      cs_n_q   <= 1'b1;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      cfg_sh_q <= '0;
      div_q    <= '0;
      wait_q   <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      valid_q  <= 1'b0;
      tmo_q    <= 1'b0;
      res_q    <= '0;
      over_q   <= 1'b0;
      under_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cs_n_q   <= cs_n_d;
      sck_q    <= sck_d;
      mosi_q   <= mosi_d;
      cfg_sh_q <= cfg_sh_d;
      div_q    <= div_d;
      wait_q   <= wait_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      valid_q  <= valid_d;
      tmo_q    <= tmo_d;
      res_q    <= res_d;
      over_q   <= over_d;
      under_q  <= under_d;
    end
  end

  assign cs_n_o         = cs_n_q;
  assign sck_o          = sck_q;
  assign mosi_o         = mosi_q;
  assign busy_o         = (state_q != ST_IDLE);
  assign result_valid_o = valid_q;
  assign result_o       = res_q;
  assign over_range_o   = over_q;
  assign under_range_o  = under_q;
  assign timeout_o      = tmo_q;
endmodule

// File: rtl/adc_serial_host_chk.sv
module adc_serial_host_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi,
  input logic        busy,
  input logic        valid,
  input logic [23:0] result,
  input logic        over,
  input logic        under,
  input logic        tmo
);
  assert_busy_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !cs_n);

  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  assert_mosi_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_valid_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (cs_n && !busy && $past(!cs_n)));

  assert_flags_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(over && under));

  assert_over_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    over |-> (result == 24'h7FFFFF));

  assert_under_sat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    under |-> (result == 24'h800000));

  assert_tmo_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> (cs_n && !valid && $past(!cs_n)));
endmodule

bind adc_serial_host adc_serial_host_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_n   (cs_n_o),
  .sck    (sck_o),
  .mosi   (mosi_o),
  .busy   (busy_o),
  .valid  (result_valid_o),
  .result (result_o),
  .over   (over_range_o),
  .under  (under_range_o),
  .tmo    (timeout_o)
);

// File: tb/tb_adc_serial_host.sv
`timescale 1ns/1ps
module tb_adc_serial_host;
  localparam int DIV_W = 4;
  localparam int TMO   = 40;
  localparam int NEVER = 1 << 30;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic en = 1'b1, sgl = 1'b0, odd = 1'b0, glbl = 1'b0, twox = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [3:0] osr = 4'd0;
  logic [DIV_W-1:0] cdiv = '0;
  logic cs_n, sck, mosi, miso, busy, valid, over, under, tmo;
  logic [23:0] res;

  int cyc = 0, n_cmp = 0, n_bad = 0;
  int t_start = -10, t_stop = -5, t_eoc = NEVER, half = 1;
  bit kind_valid = 1'b0, chk_on = 1'b0, cur_en = 1'b1, eoc_low = 1'b0;
  logic [13:0] exp_word = '0;
  logic [23:0] exp_res = '0;
  bit exp_over = 1'b0, exp_under = 1'b0;
  string res_tag = "R9";
  logic [31:0] frame = '0;
  int fall_idx = 0;
  logic prev_mosi = 1'b0;

  always #2.5 clk = ~clk;

  adc_serial_host #(.DIV_W(DIV_W), .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .cfg_en_i(en), .cfg_single_i(sgl), .cfg_odd_i(odd), .cfg_glbl_i(glbl),
    .cfg_addr_i(addr), .cfg_osr_i(osr), .cfg_twox_i(twox), .clk_div_i(cdiv),
    .cs_n_o(cs_n), .sck_o(sck), .mosi_o(mosi), .miso_i(miso),
    .busy_o(busy), .result_valid_o(valid), .result_o(res),
    .over_range_o(over), .under_range_o(under), .timeout_o(tmo)
  );

  // converter pin model: ready flag low, then one bit per falling clock
  assign miso = (cs_n || !eoc_low) ? 1'b1 :
                (fall_idx < 32) ? frame[31 - (fall_idx % 32)] : 1'b1;

  always @(negedge sck or posedge cs_n) begin
    if (cs_n) fall_idx = 0;
    else      fall_idx = fall_idx + 1;
  end

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [13:0] mk_word(input bit e, input bit s, input bit o,
      input bit g, input logic [1:0] a, input logic [3:0] r, input bit x);
    if (e) return {1'b1, 1'b0, 1'b1, s, o, g, a, r, x, 1'b0};
    return {3'b100, 11'd0};
  endfunction

  function automatic logic [31:0] in_range(input logic [23:0] v);
    return {2'b00, ~v[23], v, 5'b10101};
  endfunction

  // per-cycle reference built from the event times of the current frame
  always @(negedge clk) begin
    int n, k;
    bit inw, shw, e_sck, e_mosi;
    if (chk_on) begin
      n   = cyc;
      inw = (n >= t_start) && (n < t_stop);
      shw = (n >= t_eoc) && (n < t_stop);
      e_sck  = shw ? (((n - t_eoc) / half) % 2 == 1) : 1'b0;
      k      = shw ? (n - t_eoc) / (2 * half) : 0;
      e_mosi = (shw && k < 14) ? exp_word[13 - k] : 1'b0;
      chk("R2 cs_n", {31'd0, cs_n}, {31'd0, !inw});
      chk("R2 busy", {31'd0, busy}, {31'd0, inw});
      if (shw) chk("R4 sck", {31'd0, sck}, {31'd0, e_sck});
      else     chk("R3 sck", {31'd0, sck}, {31'd0, e_sck});
      if (cur_en) chk("R5 mosi", {31'd0, mosi}, {31'd0, e_mosi});
      else        chk("R6 mosi", {31'd0, mosi}, {31'd0, e_mosi});
      if (sck) chk("R7 mosi hold", {31'd0, mosi}, {31'd0, prev_mosi});
      chk("R8 valid", {31'd0, valid}, {31'd0, (n == t_stop) && kind_valid});
      chk("R12 timeout", {31'd0, tmo}, {31'd0, (n == t_stop) && !kind_valid});
      if (n == t_stop && kind_valid) begin
        chk({res_tag, " result"}, {8'd0, res}, {8'd0, exp_res});
        chk({res_tag, " over"}, {31'd0, over}, {31'd0, exp_over});
        chk({res_tag, " under"}, {31'd0, under}, {31'd0, exp_under});
      end
      prev_mosi = mosi;
    end
  end

  task automatic run(input bit e, input bit s, input bit o, input bit g,
      input logic [1:0] a, input logic [3:0] r, input bit x, input int dv,
      input logic [31:0] fr, input logic [23:0] er, input bit eo, input bit eu,
      input string tag, input int dly, input bit poke, input bit ready);
    @(negedge clk);
    en = e; sgl = s; odd = o; glbl = g; addr = a; osr = r; twox = x;
    cdiv = DIV_W'(dv); start = 1'b1;
    t_eoc = NEVER; t_start = cyc + 1; t_stop = t_start + TMO; kind_valid = 1'b0;
    half = dv + 1; cur_en = e; exp_word = mk_word(e, s, o, g, a, r, x);
    exp_res = er; exp_over = eo; exp_under = eu; res_tag = tag; frame = fr;
    @(negedge clk);
    start = 1'b0;
    if (ready) begin
      repeat (dly) @(negedge clk);
      eoc_low = 1'b1;
      t_eoc = cyc + 1; t_stop = t_eoc + 64 * half; kind_valid = 1'b1;
    end
    while (cyc < t_stop + 2) begin
      @(negedge clk);
      if (poke && cyc == t_eoc + 5) begin
        start = 1'b1; en = ~en; osr = ~osr; addr = ~addr;  // R2, R5: ignored mid-frame
      end else begin
        start = 1'b0;
      end
    end
    eoc_low = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cs_n", {31'd0, cs_n}, 32'd1);
    chk("R1 sck", {31'd0, sck}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 valid", {31'd0, valid}, 32'd0);
    chk("R1 timeout", {31'd0, tmo}, 32'd0);
    rst_n = 1'b1;
    chk_on = 1'b1;
    repeat (5) @(negedge clk);
    // zero input, fastest clock, ready at once
    run(1, 1, 0, 1, 2'd2, 4'h5, 1, 0, in_range(24'h000000), 24'h000000, 0, 0, "R9", 0, 0, 1);
    // minus one LSB, wider divider, late ready
    run(1, 0, 1, 0, 2'd1, 4'hA, 0, 2, in_range(24'hFFFFFF), 24'hFFFFFF, 0, 0, "R9", 7, 0, 1);
    // top in-range code with a start pulse and setup change mid-frame
    run(1, 1, 1, 1, 2'd3, 4'hF, 1, 1, in_range(24'h7FFFFF), 24'h7FFFFF, 0, 0, "R9", 3, 1, 1);
    // settings kept: enable cleared
    run(0, 1, 1, 1, 2'd3, 4'h9, 1, 3, in_range(24'h800000), 24'h800000, 0, 0, "R9", 1, 0, 1);
    // clamped above full scale
    run(1, 0, 0, 0, 2'd0, 4'h1, 0, 0, {3'b001, 24'h800000, 5'h00}, 24'h7FFFFF, 1, 0, "R10", 2, 0, 1);
    // clamped below full scale
    run(1, 1, 0, 0, 2'd1, 4'h2, 1, 1, {3'b000, 24'h7FFFFF, 5'h1F}, 24'h800000, 0, 1, "R11", 4, 0, 1);
    // ready flag never drops
    run(1, 0, 0, 0, 2'd0, 4'h3, 0, 1, 32'd0, 24'd0, 0, 0, "R12", 0, 0, 0);
    // normal frame after the timeout
    run(1, 0, 1, 1, 2'd2, 4'h6, 0, 2, in_range(24'h123456), 24'h123456, 0, 0, "R9", 5, 0, 1);
    chk_on = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule